// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block is the host-side engine that reads one page from an 8-bit NAND flash device. On a start request it latches a column address, a row address, a byte count and an ECC-mode flag. It then writes the read-setup command, the column and row address bytes and the read-confirm command over the flash bus. After that it waits for the device's ready/busy line and clocks the requested number of bytes out of the device. Each byte goes to the host over a valid/ready stream.

When the device's internal ECC is enabled, the sequencer adds three steps after the busy period. It issues a status command and reads one status byte. It then writes the read-setup command again, with no address, so the device returns to data output. The status byte's bit 0 is reported to the host as an ECC failure.

All bus strobes come from registers. The low and high widths of the write and read strobes, the wait before ready is sampled, the recovery time before the first read strobe, and a busy timeout are all parameters counted in clock cycles.

Top module: `nand_page_reader`

## Requirements
- R1: A read is written as command 00h, then COL_BYTES column bytes least significant first, then ROW_BYTES row bytes least significant first, then command 30h. nandCle is high only during command cycles, nandAle only during address cycles, never both together. Each byte is valid while nandWeN rises.
- R2: After 30h the block waits WB_CYC cycles and then until nandRbN is high. nandReN never falls while nandRbN is low.
- R3: At least RR_CYC clock cycles pass between nandRbN returning high and the next falling edge of nandReN.
- R4: With eccEn set at start, the block issues command 70h after the busy period and makes exactly one read cycle. It then issues command 00h with no address cycles before reading page data. With eccEn clear, neither 70h nor a second 00h is issued.
- R5: eccFail equals bit 0 of the status byte after an ECC-mode read. It is 0 after a read without ECC, and it is cleared by the next start.
- R6: The bytes on outData are the device bytes of consecutive columns, starting at the given column, one per nandReN pulse. Exactly byteCount bytes are delivered.
- R7: While outValid is high and outReady is low, outValid stays high and outData stays unchanged, and no further nandReN pulse occurs.
- R8: done is a single-cycle pulse after the last byte is accepted by the host. With byteCount = 0 no data read cycle occurs and done still pulses.
- R9: If nandRbN stays low for TIMEOUT_CYC cycles while the block waits for ready, the read is abandoned. errTimeout is set, done pulses, and no read strobe is issued. errTimeout is cleared by the next start.
- R10: A start pulse while cmdBusy is high is ignored. No second sequence is issued and the latched addresses are not changed.
- R11: After reset and whenever cmdBusy is low, nandWeN and nandReN are high, nandCle, nandAle, nandIoOe and outValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page read (one-cycle pulse) |
| eccEn | input | 1 | Use the on-die ECC status step |
| hostCol | input | 8*COL_BYTES | Column address of the first byte |
| hostRow | input | 8*ROW_BYTES | Row (page) address |
| byteCount | input | CNT_W | Number of bytes to read |
| cmdBusy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse at the end of a read |
| errTimeout | output | 1 | Ready/busy timeout occurred |
| eccFail | output | 1 | Device reported an ECC read error |
| outData | output | 8 | Stream data byte |
| outValid | output | 1 | outData is valid |
| outReady | input | 1 | Host accepts outData |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 8 | Bus byte driven to the device |
| nandIoOe | output | 1 | Drive enable for nandIoOut |
| nandIoIn | input | 8 | Bus byte from the device |
| nandRbN | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench uses a behavioural flash device that logs every latched command and address byte. It checks the exact sequence in both modes: a design that forgot the second 00h after the status read would stream status bytes instead of page data. It measures the gap from ready to the first read strobe, and it flags any read strobe during busy, which a design that sampled the ready line too early would produce. Further cases are a zero byte count, a stalled host, a device that never becomes ready, a start pulse in mid-read, and a failing status byte whose flag must clear on the next read; a design that left the ECC flag set would report a phantom error there.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

  localparam logic [7:0] CMD_READ_SETUP = 8'h00;
  localparam logic [7:0] CMD_READ_GO    = 8'h30;
  localparam logic [7:0] CMD_STATUS     = 8'h70;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_READ = 2'd2
  } busOp_e;

  typedef enum logic {
    TMR_WB = 1'b0,
    TMR_RR = 1'b1
  } tmrSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       latch;     // capture host request
    logic       go;        // launch one bus cycle
    busOp_e     op;
    logic [7:0] cmdCode;
    logic [3:0] addrIdx;
    logic       tmrLoad;
    tmrSel_e    tmrSel;
    logic       rdyWatch;  // count busy time for timeout
    logic       rdToStat;  // read cycle targets status register
  } ctlStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic cycDone;
    logic tmrZero;
    logic timeoutHit;
    logic rbReady;
    logic cntZero;
    logic outBusy;
  } dpStat_t;

endpackage

// File: rtl/nrd_datapath.sv
module nrd_datapath
  import nrd_pkg::*;
#(
  parameter int COL_BYTES   = 2,
  parameter int ROW_BYTES   = 3,
  parameter int CNT_W       = 16,
  parameter int WE_LOW      = 2,
  parameter int WE_HIGH     = 2,
  parameter int RE_LOW      = 2,
  parameter int RE_HIGH     = 2,
  parameter int WB_CYC      = 4,
  parameter int RR_CYC      = 3,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctlStrb_t               ctl,
  output dpStat_t                st,
  input  logic [8*COL_BYTES-1:0] hostCol,
  input  logic [8*ROW_BYTES-1:0] hostRow,
  input  logic [CNT_W-1:0]       byteCount,
  output logic                   eccFail,
  output logic [7:0]             outData,
  output logic                   outValid,
  input  logic                   outReady,
  output logic                   nandCle,
  output logic                   nandAle,
  output logic                   nandWeN,
  output logic                   nandReN,
  output logic [7:0]             nandIoOut,
  output logic                   nandIoOe,
  input  logic [7:0]             nandIoIn,
  input  logic                   nandRbN
);

  localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
  localparam int WR_MAX = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int RD_MAX = (RE_LOW > RE_HIGH) ? RE_LOW : RE_HIGH;
  localparam int PH_MAX = (WR_MAX > RD_MAX) ? WR_MAX : RD_MAX;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TM_MAX = (WB_CYC > RR_CYC) ? WB_CYC : RR_CYC;
  localparam int TM_W   = $clog2(TM_MAX + 1);
  localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);

  // latched request
  logic [8*ADDR_BYTES-1:0] addrQ;
  logic [CNT_W-1:0]        cntQ;

  // bus cycle engine
  logic            busy, inLow, rdStatQ;
  logic [PH_W-1:0] phCnt;
  busOp_e          opQ;
  logic [7:0]      byteQ;
  logic [7:0]      addrByte;
  logic [PH_W-1:0] lowLast, highLast;
  logic            lowEnd, highEnd;

  // waits
  logic [1:0]      rbSync;
  logic [TM_W-1:0] tmrQ;
  logic [TO_W-1:0] toCnt;

  // output stage and status
  logic [7:0] outDataQ;
  logic       outValidQ;
  logic       statBadQ;

  // select address byte by index
  always_comb begin
    addrByte = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (ctl.addrIdx == 4'(i)) addrByte = addrQ[i*8 +: 8];
    end
  end

  always_comb begin
    if (opQ == OP_READ) begin
      lowLast  = PH_W'(RE_LOW - 1);
      highLast = PH_W'(RE_HIGH - 1);
    end else begin
      lowLast  = PH_W'(WE_LOW - 1);
      highLast = PH_W'(WE_HIGH - 1);
    end
    lowEnd  = busy && inLow && (phCnt == lowLast);
    highEnd = busy && !inLow && (phCnt == highLast);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      cntQ  <= '0;
    end else if (ctl.latch) begin
      addrQ <= {hostRow, hostCol};
      cntQ  <= byteCount;
    end else if (lowEnd && opQ == OP_READ && !rdStatQ) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      inLow   <= 1'b0;
      phCnt   <= '0;
      opQ     <= OP_READ;
      byteQ   <= 8'h00;
      rdStatQ <= 1'b0;
    end else if (ctl.go && !busy) begin
      busy    <= 1'b1;
      inLow   <= 1'b1;
      phCnt   <= '0;
      opQ     <= ctl.op;
      byteQ   <= (ctl.op == OP_CMD) ? ctl.cmdCode : addrByte;
      rdStatQ <= ctl.rdToStat;
    end else if (busy) begin
      if (lowEnd) begin
        inLow <= 1'b0;
        phCnt <= '0;
      end else if (highEnd) begin
        busy  <= 1'b0;
        phCnt <= '0;
      end else begin
        phCnt <= phCnt + PH_W'(1);
      end
    end
  end

  // capture on the read strobe's rising edge; stream handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outDataQ  <= 8'h00;
      outValidQ <= 1'b0;
      statBadQ  <= 1'b0;
    end else begin
      if (outValidQ && outReady) outValidQ <= 1'b0;
      if (ctl.latch) statBadQ <= 1'b0;
      if (lowEnd && opQ == OP_READ) begin
        if (rdStatQ) begin
          statBadQ <= nandIoIn[0];
        end else begin
          outDataQ  <= nandIoIn;
          outValidQ <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbSync <= 2'b00;
      tmrQ   <= '0;
      toCnt  <= '0;
    end else begin
      rbSync <= {rbSync[0], nandRbN};
      if (ctl.tmrLoad)
        tmrQ <= (ctl.tmrSel == TMR_WB) ? TM_W'(WB_CYC) : TM_W'(RR_CYC);
      else if (tmrQ != '0)
        tmrQ <= tmrQ - TM_W'(1);
      if (!ctl.rdyWatch)
        toCnt <= '0;
      else if (!rbSync[1] && toCnt < TO_W'(TIMEOUT_CYC))
        toCnt <= toCnt + TO_W'(1);
    end
  end

  always_comb begin
    st.cycDone    = highEnd;
    st.tmrZero    = (tmrQ == '0);
    st.timeoutHit = (toCnt >= TO_W'(TIMEOUT_CYC));
    st.rbReady    = rbSync[1];
    st.cntZero    = (cntQ == '0);
    st.outBusy    = outValidQ;
  end

  assign nandWeN   = !(busy && inLow && opQ != OP_READ);
  assign nandReN   = !(busy && inLow && opQ == OP_READ);
  assign nandCle   = busy && (opQ == OP_CMD);
  assign nandAle   = busy && (opQ == OP_ADDR);
  assign nandIoOe  = busy && (opQ != OP_READ);
  assign nandIoOut = byteQ;
  assign outData   = outDataQ;
  assign outValid  = outValidQ;
  assign eccFail   = statBadQ;

endmodule

// File: rtl/nrd_ctrl.sv
module nrd_ctrl
  import nrd_pkg::*;
#(
  parameter int ADDR_BYTES = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     eccEn,
  input  dpStat_t  st,
  output ctlStrb_t ctl,
  output logic     cmdBusy,
  output logic     done,
  output logic     errTimeout
);

  typedef enum logic [3:0] {
    S_IDLE, S_C00, S_ADDR, S_C30, S_WB, S_RDY, S_C70, S_RR1,
    S_STAT, S_C00B, S_RR2, S_CHK, S_READ, S_HOLD, S_FIN
  } state_e;

  state_e     state;
  logic       launched, eccQ, errToQ;
  logic [3:0] addrIdx;
  logic       issueState;

  always_comb begin
    issueState = (state == S_C00) || (state == S_ADDR) || (state == S_C30) ||
                 (state == S_C70) || (state == S_STAT) || (state == S_C00B) ||
                 (state == S_READ);
    ctl          = '0;
    ctl.op       = OP_CMD;
    ctl.tmrSel   = TMR_WB;
    ctl.addrIdx  = addrIdx;
    ctl.go       = issueState && !launched;
    ctl.rdyWatch = (state == S_RDY);
    unique case (state)
      S_IDLE: ctl.latch = start;
      S_C00, S_C00B: ctl.cmdCode = CMD_READ_SETUP;
      S_ADDR: ctl.op = OP_ADDR;
      S_C30: begin
        ctl.cmdCode = CMD_READ_GO;
        ctl.tmrLoad = st.cycDone;
      end
      S_C70: begin
        ctl.cmdCode = CMD_STATUS;
        ctl.tmrLoad = st.cycDone;
        ctl.tmrSel  = TMR_RR;
      end
      S_STAT: begin
        ctl.op       = OP_READ;
        ctl.rdToStat = 1'b1;
      end
      S_READ: ctl.op = OP_READ;
      S_RDY: begin
        ctl.tmrLoad = !st.timeoutHit && st.rbReady && !eccQ;
        ctl.tmrSel  = TMR_RR;
      end
      default: ;
    endcase
    if (state == S_C00B) begin
      ctl.tmrLoad = st.cycDone;
      ctl.tmrSel  = TMR_RR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      launched <= 1'b0;
      eccQ     <= 1'b0;
      errToQ   <= 1'b0;
      addrIdx  <= '0;
    end else begin
      if (issueState) begin
        if (st.cycDone) launched <= 1'b0;
        else if (ctl.go) launched <= 1'b1;
      end
      unique case (state)
        S_IDLE: if (start) begin
          eccQ    <= eccEn;
          errToQ  <= 1'b0;
          addrIdx <= '0;
          state   <= S_C00;
        end
        S_C00: if (st.cycDone) state <= S_ADDR;
        S_ADDR: if (st.cycDone) begin
          if (addrIdx == 4'(ADDR_BYTES - 1)) state <= S_C30;
          addrIdx <= addrIdx + 4'd1;
        end
        S_C30: if (st.cycDone) state <= S_WB;
        S_WB:  if (st.tmrZero) state <= S_RDY;
        S_RDY: begin
          if (st.timeoutHit) begin
            errToQ <= 1'b1;
            state  <= S_FIN;
          end else if (st.rbReady) begin
            state <= eccQ ? S_C70 : S_RR2;
          end
        end
        S_C70:  if (st.cycDone) state <= S_RR1;
        S_RR1:  if (st.tmrZero) state <= S_STAT;
        S_STAT: if (st.cycDone) state <= S_C00B;
        S_C00B: if (st.cycDone) state <= S_RR2;
        S_RR2:  if (st.tmrZero) state <= S_CHK;
        S_CHK:  state <= st.cntZero ? S_FIN : S_READ;
        S_READ: if (st.cycDone) state <= S_HOLD;
        S_HOLD: if (!st.outBusy) state <= S_CHK;
        S_FIN:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmdBusy    = (state != S_IDLE);
  assign done       = (state == S_FIN);
  assign errTimeout = errToQ;

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nrd_pkg::*;
#(
  parameter int COL_BYTES   = 2,
  parameter int ROW_BYTES   = 3,
  parameter int CNT_W       = 16,
  parameter int WE_LOW      = 2,
  parameter int WE_HIGH     = 2,
  parameter int RE_LOW      = 2,
  parameter int RE_HIGH     = 2,
  parameter int WB_CYC      = 4,
  parameter int RR_CYC      = 3,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   eccEn,
  input  logic [8*COL_BYTES-1:0] hostCol,
  input  logic [8*ROW_BYTES-1:0] hostRow,
  input  logic [CNT_W-1:0]       byteCount,
  output logic                   cmdBusy,
  output logic                   done,
  output logic                   errTimeout,
  output logic                   eccFail,
  output logic [7:0]             outData,
  output logic                   outValid,
  input  logic                   outReady,
  output logic                   nandCle,
  output logic                   nandAle,
  output logic                   nandWeN,
  output logic                   nandReN,
  output logic [7:0]             nandIoOut,
  output logic                   nandIoOe,
  input  logic [7:0]             nandIoIn,
  input  logic                   nandRbN
);

  localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;

  ctlStrb_t ctl;
  dpStat_t  st;

  nrd_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .eccEn      (eccEn),
    .st         (st),
    .ctl        (ctl),
    .cmdBusy    (cmdBusy),
    .done       (done),
    .errTimeout (errTimeout)
  );

  nrd_datapath #(
    .COL_BYTES  (COL_BYTES),
    .ROW_BYTES  (ROW_BYTES),
    .CNT_W      (CNT_W),
    .WE_LOW     (WE_LOW),
    .WE_HIGH    (WE_HIGH),
    .RE_LOW     (RE_LOW),
    .RE_HIGH    (RE_HIGH),
    .WB_CYC     (WB_CYC),
    .RR_CYC     (RR_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .st        (st),
    .hostCol   (hostCol),
    .hostRow   (hostRow),
    .byteCount (byteCount),
    .eccFail   (eccFail),
    .outData   (outData),
    .outValid  (outValid),
    .outReady  (outReady),
    .nandCle   (nandCle),
    .nandAle   (nandAle),
    .nandWeN   (nandWeN),
    .nandReN   (nandReN),
    .nandIoOut (nandIoOut),
    .nandIoOe  (nandIoOe),
    .nandIoIn  (nandIoIn),
    .nandRbN   (nandRbN)
  );

endmodule

// File: rtl/nrd_checker.sv
module nrd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmdBusy,
  input logic       done,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       nandCle,
  input logic       nandAle,
  input logic       nandWeN,
  input logic       nandReN,
  input logic       nandIoOe,
  input logic       nandRbN
);

  assert_cle_ale_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(nandCle && nandAle));

  assert_latch_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (nandCle || nandAle) |-> (nandIoOe && nandReN));

  assert_no_read_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nandReN |-> nandRbN);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && nandReN));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdBusy |-> (nandWeN && nandReN && !nandCle && !nandAle && !nandIoOe && !outValid));

endmodule

bind nand_page_reader nrd_checker u_nrd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmdBusy  (cmdBusy),
  .done     (done),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .nandCle  (nandCle),
  .nandAle  (nandAle),
  .nandWeN  (nandWeN),
  .nandReN  (nandReN),
  .nandIoOe (nandIoOe),
  .nandRbN  (nandRbN)
);

// File: tb/test_nand_page_reader.sv
`timescale 1ns/1ps
module test_nand_page_reader;

  localparam int RR_CYC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        eccEn = 1'b0;
  logic [15:0] hostCol = '0;
  logic [23:0] hostRow = '0;
  logic [15:0] byteCount = '0;
  logic        cmdBusy, done, errTimeout, eccFail;
  logic [7:0]  outData;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic [7:0]  nandIoOut;
  logic [7:0]  nandIoIn = 8'h00;
  logic        nandRbN = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc++;

  nand_page_reader #(.RR_CYC(RR_CYC)) i_nand_page_reader (.*);

  // ---------------- behavioural flash device ----------------
  logic [7:0] logByte [32];
  bit         logCmd  [32];
  int         logN;
  logic [7:0] addrSeen [5];
  int         addrK = 0;
  bit         modeStat = 0;
  int         mcol = 0;
  int         busyLen = 20;
  int         busyLeft = 0;
  bit         busyReq = 0;
  logic [7:0] statusByte = 8'h00;
  int         dataReads, statReads, busyViol;
  int         rbRiseCyc, firstReCyc;
  int         doneCnt;
  int         readyMode = 0;
  logic [7:0] rxData [64];
  int         rxN;

  function automatic logic [7:0] pageByte(input int c);
    return 8'((c * 5) + 60);
  endfunction

  always @(posedge nandWeN) begin
    if (logN < 32) begin
      logByte[logN] = nandIoOut;
      logCmd[logN]  = nandCle;
      logN++;
    end
    if (nandCle) begin
      addrK = 0;
      if (nandIoOut == 8'h70) modeStat = 1;
      else modeStat = 0;
      if (nandIoOut == 8'h30) begin
        mcol = {addrSeen[1], addrSeen[0]};
        busyReq = 1;
      end
    end else if (nandAle) begin
      if (addrK < 5) addrSeen[addrK] = nandIoOut;
      addrK++;
    end
  end

  always @(negedge clk) begin
    if (busyReq) begin
      busyReq  = 0;
      nandRbN  = 1'b0;
      busyLeft = busyLen;
    end else if (busyLeft > 0) begin
      busyLeft--;
      if (busyLeft == 0) begin
        nandRbN   = 1'b1;
        rbRiseCyc = cyc;
      end
    end
  end

  always @(negedge nandReN) begin
    if (!nandRbN) busyViol++;
    if (firstReCyc < 0) firstReCyc = cyc;
    if (modeStat) begin
      nandIoIn = statusByte;
      statReads++;
    end else begin
      nandIoIn = pageByte(mcol);
      dataReads++;
    end
  end

  always @(posedge nandReN) if (!modeStat) mcol++;

  // ---------------- host side monitors / drivers ----------------
  always @(negedge clk) begin
    if (outValid && outReady && rxN < 64) begin
      rxData[rxN] = outData;
      rxN++;
    end
    if (done) doneCnt++;
  end

  always @(posedge clk) begin
    #1;
    if (readyMode == 0) outReady = 1'b1;
    else outReady = (cyc % 3 == 0) || (cyc % 7 == 0);
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    logN = 0; dataReads = 0; statReads = 0; busyViol = 0;
    rbRiseCyc = -1; firstReCyc = -1; doneCnt = 0; rxN = 0;
  endtask

  task automatic run_read(input logic [15:0] c, input logic [23:0] r,
                          input logic [15:0] n, input bit e, input bit poke);
    clear_model();
    @(posedge clk); #1;
    hostCol = c; hostRow = r; byteCount = n; eccEn = e; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (20) @(posedge clk);
      #1; hostCol = 16'hFFFF; hostRow = 24'hFFFFFF; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_log(input string req, input bit e,
                           input logic [15:0] c, input logic [23:0] r);
    logic [7:0] expB [9];
    bit         expC [9];
    int         expN;
    bit         ok;
    expB[0] = 8'h00; expC[0] = 1;
    expB[1] = c[7:0];   expC[1] = 0;
    expB[2] = c[15:8];  expC[2] = 0;
    expB[3] = r[7:0];   expC[3] = 0;
    expB[4] = r[15:8];  expC[4] = 0;
    expB[5] = r[23:16]; expC[5] = 0;
    expB[6] = 8'h30; expC[6] = 1;
    expB[7] = 8'h70; expC[7] = 1;
    expB[8] = 8'h00; expC[8] = 1;
    expN = e ? 9 : 7;
    check(logN == expN, req, "bus cycle count", logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      ok = (logByte[i] == expB[i]) && (logCmd[i] == expC[i]);
      check(ok, req, $sformatf("bus byte %0d (cmd=%0d)", i, logCmd[i]),
            logByte[i], expB[i]);
    end
  endtask

  task automatic check_data(input string req, input int c, input int n);
    check(rxN == n, req, "bytes delivered", rxN, n);
    for (int i = 0; i < n && i < rxN; i++)
      check(rxData[i] == pageByte(c + i), req, $sformatf("byte %0d", i),
            rxData[i], pageByte(c + i));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(nandWeN && nandReN && !nandCle && !nandAle && !nandIoOe, "R11",
          "bus idle after reset", {nandWeN, nandReN, nandCle, nandAle, nandIoOe}, 5'b11000);
    check(!outValid && !cmdBusy && !done, "R11", "host side idle",
          {outValid, cmdBusy, done}, 0);
  endtask

  task automatic t_plain();
    busyLen = 25; readyMode = 0;
    run_read(16'h0123, 24'h0A0B0C, 16'd8, 1'b0, 1'b0);
    check_log("R1", 1'b0, 16'h0123, 24'h0A0B0C);
    check(busyViol == 0, "R2", "read strobes during busy", busyViol, 0);
    check(firstReCyc - rbRiseCyc >= RR_CYC, "R3", "ready-to-read gap",
          firstReCyc - rbRiseCyc, RR_CYC);
    check_data("R6", 16'h0123, 8);
    check(dataReads == 8, "R6", "read pulses", dataReads, 8);
    check(doneCnt == 1, "R8", "done pulses", doneCnt, 1);
    check(eccFail == 0, "R5", "eccFail without ECC", eccFail, 0);
    check(errTimeout == 0, "R9", "no timeout", errTimeout, 0);
  endtask

  task automatic t_ecc_pass();
    busyLen = 30; statusByte = 8'hE0; readyMode = 0;
    run_read(16'h0040, 24'h000102, 16'd5, 1'b1, 1'b0);
    check_log("R4", 1'b1, 16'h0040, 24'h000102);
    check(statReads == 1, "R4", "status reads", statReads, 1);
    check(firstReCyc - rbRiseCyc >= RR_CYC, "R3", "ready-to-status gap",
          firstReCyc - rbRiseCyc, RR_CYC);
    check_data("R6", 16'h0040, 5);
    check(eccFail == 0, "R5", "eccFail on good status", eccFail, 0);
  endtask

  task automatic t_ecc_fail();
    busyLen = 15; statusByte = 8'hC1; readyMode = 0;
    run_read(16'h0200, 24'h112233, 16'd4, 1'b1, 1'b0);
    check(eccFail == 1, "R5", "eccFail on bad status", eccFail, 1);
    check_data("R6", 16'h0200, 4);
    statusByte = 8'h00;
    busyLen = 15;
    run_read(16'h0010, 24'h000001, 16'd2, 1'b0, 1'b0);
    check(eccFail == 0, "R5", "eccFail cleared by next start", eccFail, 0);
    check_log("R4", 1'b0, 16'h0010, 24'h000001);
  endtask

  task automatic t_zero();
    busyLen = 12; readyMode = 0;
    run_read(16'h0005, 24'h000077, 16'd0, 1'b0, 1'b0);
    check(dataReads == 0, "R8", "no data reads with zero count", dataReads, 0);
    check(doneCnt == 1, "R8", "done with zero count", doneCnt, 1);
    check(rxN == 0, "R8", "no stream bytes", rxN, 0);
  endtask

  task automatic t_stall();
    busyLen = 18; readyMode = 1;
    run_read(16'h0300, 24'h00AA00, 16'd12, 1'b0, 1'b0);
    readyMode = 0;
    check_data("R7", 16'h0300, 12);
    check(dataReads == 12, "R7", "read pulses under stall", dataReads, 12);
  endtask

  task automatic t_timeout();
    busyLen = 3000; readyMode = 0;
    run_read(16'h0001, 24'h000002, 16'd4, 1'b1, 1'b0);
    check(errTimeout == 1, "R9", "timeout flag", errTimeout, 1);
    check(doneCnt == 1, "R9", "done after timeout", doneCnt, 1);
    check(dataReads + statReads == 0, "R9", "read strobes after timeout",
          dataReads + statReads, 0);
    check(!cmdBusy, "R9", "idle after timeout", cmdBusy, 0);
    while (busyLeft > 0) @(negedge clk);
    busyLen = 10;
    run_read(16'h0001, 24'h000002, 16'd1, 1'b0, 1'b0);
    check(errTimeout == 0, "R9", "timeout cleared by next start", errTimeout, 0);
  endtask

  task automatic t_start_busy();
    busyLen = 20; readyMode = 0;
    run_read(16'h0050, 24'h030201, 16'd3, 1'b0, 1'b1);
    check_log("R10", 1'b0, 16'h0050, 24'h030201);
    check(doneCnt == 1, "R10", "single completion", doneCnt, 1);
    check_data("R10", 16'h0050, 3);
    check(!cmdBusy, "R10", "idle afterwards", cmdBusy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_plain();
    t_ecc_pass();
    t_ecc_fail();
    t_zero();
    t_stall();
    t_timeout();
    t_start_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule